// File: doc/BRIEF.md
# Bus Message Timing Unit

This block supplies the three time bases that a command/response serial avionics bus engine needs around each message. It waits a programmable gap before the controller may start its next message. It watches for a responding terminal's status word and flags a response timeout. It also guards the transmitter against a transmission that never stops. An external encoder/decoder reports bus events as single-cycle strobes. The block answers with single-cycle pulses, plus one sticky flag for the host.

The system clock runs at either 16 MHz or 12 MHz, and the `clk_sel` pin says which. Each timer has its own prescaler, which restarts on the timer's start event. Its intervals therefore count an exact number of clock cycles from that event. No data stream passes through the block, so it has no valid/ready interface. Every pin is a plain level or strobe that is sampled on the rising clock edge.

Top module: `bus_msg_timer`

## Requirements
- R1: A synchronous `rst` held high for one or more cycles stops every timer and drives `resp_timeout`, `gap_done`, `wdog_trip` and `wdog_flag` to 0. A timer that was running before reset produces no later pulse.
- R2: A `cmd_mid_parity` strobe starts the response timer. The value of `tmo_sel` sampled with the strobe picks the limit: 0 = 18.5 µs, 1 = 22.5 µs, 2 = 50.5 µs, 3 = 128.0 µs. `resp_timeout` is high in the cycle that begins exactly limit × 16 clock cycles (clk_sel = 0) or limit × 12 cycles (clk_sel = 1) after the edge that sampled the strobe.
- R3: A `stat_mid_sync` strobe that arrives while the response timer runs stops it, and no timeout follows. This also holds when the strobe is sampled on the same edge at which the limit would expire. A strobe that comes one cycle later does not cancel a timeout that has already been raised.
- R4: A `cmd_mid_parity` strobe that arrives while the response timer runs restarts the full interval from the new strobe.
- R5: `resp_timeout` is never high for two cycles in a row.
- R6: A `msg_end` strobe loads `gap_len` (G, in µs). `gap_done` is then high in the cycle that begins max(G,1) µs after the loading edge. One µs is 16 cycles when clk_sel = 0 and 12 cycles when clk_sel = 1.
- R7: `gap_done` lasts one cycle. A `msg_end` that arrives during a running gap reloads the count and restarts the gap.
- R8: `tx_start` arms the transmitter watchdog. If 668 µs pass without `tx_end`, `wdog_trip` goes high for one cycle, starting 668 × 16 (or × 12) cycles after the arming edge.
- R9: `tx_end` stops the watchdog so that it does not trip. A `tx_start` that arrives while the watchdog runs restarts the 668 µs window.
- R10: `wdog_flag` is set in the same cycle as `wdog_trip` and stays set until `wdog_clr`. If a trip and `wdog_clr` fall on the same edge, the trip wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 16 or 12 MHz |
| rst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 1 | 0: 16 MHz clock, 1: 12 MHz clock |
| tmo_sel | input | 2 | Response timeout choice, sampled with cmd_mid_parity |
| gap_len | input | 16 | Intermessage gap in µs, sampled with msg_end |
| cmd_mid_parity | input | 1 | Strobe: command word mid-parity, starts response timer |
| stat_mid_sync | input | 1 | Strobe: status word mid-sync, stops response timer |
| tx_start | input | 1 | Strobe: transmitter turned on |
| tx_end | input | 1 | Strobe: transmitter turned off |
| msg_end | input | 1 | Strobe: message finished, starts gap |
| wdog_clr | input | 1 | Host clear of the sticky watchdog flag |
| resp_timeout | output | 1 | One-cycle pulse: no status in time |
| gap_done | output | 1 | One-cycle pulse: gap elapsed |
| wdog_trip | output | 1 | One-cycle pulse: transmission cut off |
| wdog_flag | output | 1 | Sticky watchdog trip indication |

## Verification
Two events can collide in one cycle. The first collision is a status mid-sync that lands on the edge where the response limit runs out. The bench waits 295 cycles after the command strobe at 16 MHz with the 18.5 µs limit, then places the mid-sync strobe so that it is sampled on the 296th edge. It expects no timeout pulse, and it checks that a strobe one edge later still lets the pulse through. The second collision is a host clear on the watchdog's expiry edge. There the bench expects the trip pulse and a flag that is still set.

// File: rtl/msg_timer_pkg.sv
package msg_timer_pkg;

  localparam int unsigned HALF_US_W = 9;

  typedef enum logic [1:0] {
    TMO_18P5  = 2'd0,
    TMO_22P5  = 2'd1,
    TMO_50P5  = 2'd2,
    TMO_128P0 = 2'd3
  } tmo_sel_e;

  // response limit expressed in half-microsecond units
  function automatic logic [HALF_US_W-1:0] tmo_half_us(input logic [1:0] sel);
    case (tmo_sel_e'(sel))
      TMO_18P5:  tmo_half_us = HALF_US_W'(37);
      TMO_22P5:  tmo_half_us = HALF_US_W'(45);
      TMO_50P5:  tmo_half_us = HALF_US_W'(101);
      TMO_128P0: tmo_half_us = HALF_US_W'(256);
      default:   tmo_half_us = HALF_US_W'(256);
    endcase
  endfunction

endpackage

// File: rtl/mtc_tick_div.sv
module mtc_tick_div #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [DIV_W-1:0] period,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && !clr && (cnt_q == (period - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || clr || !run) cnt_q <= '0;
    else if (tick)          cnt_q <= '0;
    else                    cnt_q <= cnt_q + DIV_W'(1);
  end

  // periods are at least 2 cycles, so ticks never touch
  assert_tick_spaced_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/mtc_resp_timer.sv
module mtc_resp_timer
  import msg_timer_pkg::*;
#(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] half_div,
  input  logic [1:0]       sel,
  input  logic             start,
  input  logic             stop,
  output logic             timeout_o
);

  logic                 run_q;
  logic [HALF_US_W-1:0] units_q;
  logic [HALF_US_W-1:0] lim_q;
  logic                 htick;

  mtc_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(start), .run(run_q),
    .period(half_div), .tick(htick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      units_q   <= '0;
      lim_q     <= '0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      if (start) begin
        run_q   <= 1'b1;
        units_q <= '0;
        lim_q   <= tmo_half_us(sel);
      end else if (stop) begin
        run_q <= 1'b0;
      end else if (run_q && htick) begin
        if (units_q == lim_q - HALF_US_W'(1)) begin
          run_q     <= 1'b0;
          timeout_o <= 1'b1;
        end else begin
          units_q <= units_q + HALF_US_W'(1);
        end
      end
    end
  end

  assert_sync_cancels_R3: assert property (@(posedge clk) disable iff (rst)
    (stop && !start) |=> !timeout_o);
  assert_restart_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    start |=> !timeout_o);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o);

endmodule

// File: rtl/mtc_gap_timer.sv
module mtc_gap_timer #(
  parameter int unsigned DIV_W = 5,
  parameter int unsigned GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] us_div,
  input  logic [GAP_W-1:0] len,
  input  logic             load,
  output logic             done_o
);

  logic             run_q;
  logic [GAP_W-1:0] cnt_q;
  logic             utick;

  mtc_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(load), .run(run_q),
    .period(us_div), .tick(utick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (load) begin
        run_q <= 1'b1;
        cnt_q <= len;
      end else if (run_q && utick) begin
        if (cnt_q <= GAP_W'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - GAP_W'(1);
        end
      end
    end
  end

  assert_gap_min_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> !done_o);
  assert_gap_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: rtl/mtc_tx_watchdog.sv
module mtc_tx_watchdog #(
  parameter int unsigned DIV_W    = 5,
  parameter int unsigned LIMIT_US = 668
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] us_div,
  input  logic             tx_on,
  input  logic             tx_off,
  input  logic             clr,
  output logic             trip_o,
  output logic             flag_o
);

  localparam int unsigned UW = $clog2(LIMIT_US + 1);

  logic          run_q;
  logic [UW-1:0] units_q;
  logic          utick;
  logic          expire;

  mtc_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .clr(tx_on), .run(run_q),
    .period(us_div), .tick(utick)
  );

  assign expire = run_q && utick && !tx_on && !tx_off &&
                  (units_q == UW'(LIMIT_US - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      units_q <= '0;
      trip_o  <= 1'b0;
      flag_o  <= 1'b0;
    end else begin
      trip_o <= expire;
      if (expire)   flag_o <= 1'b1;
      else if (clr) flag_o <= 1'b0;
      if (tx_on) begin
        run_q   <= 1'b1;
        units_q <= '0;
      end else if (tx_off || expire) begin
        run_q   <= 1'b0;
        units_q <= '0;
      end else if (run_q && utick) begin
        units_q <= units_q + UW'(1);
      end
    end
  end

  assert_trip_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    trip_o |=> !trip_o);
  assert_end_stops_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_off && !tx_on) |=> !trip_o);
  assert_flag_rise_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> trip_o);
  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr) |=> flag_o);

endmodule

// File: rtl/bus_msg_timer.sv
module bus_msg_timer #(
  parameter int unsigned US_DIV_FAST = 16,
  parameter int unsigned US_DIV_SLOW = 12,
  parameter int unsigned GAP_W       = 16,
  parameter int unsigned WDOG_US     = 668
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_sel,
  input  logic [1:0]       tmo_sel,
  input  logic [GAP_W-1:0] gap_len,
  input  logic             cmd_mid_parity,
  input  logic             stat_mid_sync,
  input  logic             tx_start,
  input  logic             tx_end,
  input  logic             msg_end,
  input  logic             wdog_clr,
  output logic             resp_timeout,
  output logic             gap_done,
  output logic             wdog_trip,
  output logic             wdog_flag
);

  localparam int unsigned DIV_W = $clog2(US_DIV_FAST + 1);

  logic [DIV_W-1:0] us_div;
  logic [DIV_W-1:0] half_div;

  assign us_div   = clk_sel ? DIV_W'(US_DIV_SLOW) : DIV_W'(US_DIV_FAST);
  assign half_div = us_div >> 1;

  mtc_resp_timer #(.DIV_W(DIV_W)) u_resp (
    .clk(clk), .rst(rst), .half_div(half_div), .sel(tmo_sel),
    .start(cmd_mid_parity), .stop(stat_mid_sync), .timeout_o(resp_timeout)
  );

  mtc_gap_timer #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst(rst), .us_div(us_div), .len(gap_len),
    .load(msg_end), .done_o(gap_done)
  );

  mtc_tx_watchdog #(.DIV_W(DIV_W), .LIMIT_US(WDOG_US)) u_wdog (
    .clk(clk), .rst(rst), .us_div(us_div), .tx_on(tx_start),
    .tx_off(tx_end), .clr(wdog_clr), .trip_o(wdog_trip), .flag_o(wdog_flag)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !(resp_timeout || gap_done || wdog_trip || wdog_flag));

endmodule

// File: tb/bus_msg_timer_tb.sv
`timescale 1ns/1ps
module bus_msg_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clk_sel = 1'b0;
  logic [1:0]  tmo_sel = 2'd0;
  logic [15:0] gap_len = 16'd0;
  logic        cmd_mid_parity = 1'b0, stat_mid_sync = 1'b0;
  logic        tx_start = 1'b0, tx_end = 1'b0, msg_end = 1'b0, wdog_clr = 1'b0;
  logic        resp_timeout, gap_done, wdog_trip, wdog_flag;

  int n_run = 0;
  int n_fail = 0;
  int n_to = 0, n_gd = 0, n_wt = 0;

  always #2 clk = ~clk;

  bus_msg_timer u_dut (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .tmo_sel(tmo_sel),
    .gap_len(gap_len), .cmd_mid_parity(cmd_mid_parity),
    .stat_mid_sync(stat_mid_sync), .tx_start(tx_start), .tx_end(tx_end),
    .msg_end(msg_end), .wdog_clr(wdog_clr), .resp_timeout(resp_timeout),
    .gap_done(gap_done), .wdog_trip(wdog_trip), .wdog_flag(wdog_flag)
  );

  always @(posedge clk) begin
    if (resp_timeout) n_to <= n_to + 1;
    if (gap_done)     n_gd <= n_gd + 1;
    if (wdog_trip)    n_wt <= n_wt + 1;
  end

  // kind: 0 response timer, 1 gap timer, 2 watchdog; cyc = cycles to pulse
  typedef struct packed {
    logic [1:0]  kind;
    logic        csel;
    logic [15:0] arg;
    logic [15:0] cyc;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 16'd0, 16'd296},
    '{2'd0, 1'b1, 16'd0, 16'd222},
    '{2'd0, 1'b0, 16'd1, 16'd360},
    '{2'd0, 1'b1, 16'd2, 16'd606},
    '{2'd0, 1'b0, 16'd3, 16'd2048},
    '{2'd0, 1'b1, 16'd3, 16'd1536},
    '{2'd1, 1'b0, 16'd5, 16'd80},
    '{2'd1, 1'b1, 16'd3, 16'd36},
    '{2'd1, 1'b0, 16'd0, 16'd16},
    '{2'd1, 1'b1, 16'd1, 16'd12},
    '{2'd2, 1'b0, 16'd0, 16'd10688},
    '{2'd2, 1'b1, 16'd0, 16'd8016}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input int which);
    case (which)
      0: cmd_mid_parity = 1'b1;
      1: stat_mid_sync  = 1'b1;
      2: msg_end        = 1'b1;
      3: tx_start       = 1'b1;
      4: tx_end         = 1'b1;
      default: wdog_clr = 1'b1;
    endcase
    @(negedge clk);
    cmd_mid_parity = 1'b0; stat_mid_sync = 1'b0; msg_end = 1'b0;
    tx_start = 1'b0; tx_end = 1'b0; wdog_clr = 1'b0;
  endtask

  function automatic int out_of(input int k);
    case (k)
      0: out_of = int'(resp_timeout);
      1: out_of = int'(gap_done);
      default: out_of = int'(wdog_trip);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset outputs", int'({resp_timeout, gap_done, wdog_trip, wdog_flag}), 0);
    @(negedge clk);

    // R2 R6 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      string req;
      req = (VEC[i].kind == 2'd0) ? "R2" : (VEC[i].kind == 2'd1) ? "R6" : "R8";
      clk_sel = VEC[i].csel;
      tmo_sel = VEC[i].arg[1:0];
      gap_len = VEC[i].arg;
      strobe((VEC[i].kind == 2'd0) ? 0 : (VEC[i].kind == 2'd1) ? 2 : 3);
      repeat (int'(VEC[i].cyc) - 1) @(negedge clk);
      chk({req, " not early"}, out_of(VEC[i].kind), 0);
      @(negedge clk);
      chk({req, " on time"}, out_of(VEC[i].kind), 1);
      @(negedge clk);
      chk({req, " one cycle (R5/R7)"}, out_of(VEC[i].kind), 0);
    end
    chk("R10 flag sticky", int'(wdog_flag), 1);

    // R1: reset clears flag and cancels a running watchdog
    clk_sel = 1'b0;
    strobe(3);
    repeat (100) @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    chk("R1 flag after reset", int'(wdog_flag), 0);
    c = n_wt;
    repeat (11000) @(negedge clk);
    chk("R1 no trip after reset", n_wt, c);

    // R3: status early
    tmo_sel = 2'd0;
    c = n_to;
    strobe(0); repeat (100) @(negedge clk); strobe(1);
    repeat (400) @(negedge clk);
    chk("R3 early status", n_to, c);
    // R3: status on expiry edge
    strobe(0); repeat (295) @(negedge clk); strobe(1);
    repeat (20) @(negedge clk);
    chk("R3 status on expiry edge", n_to, c);
    // R3: status one edge late
    strobe(0); repeat (296) @(negedge clk); strobe(1);
    repeat (20) @(negedge clk);
    chk("R3 late status", n_to, c + 1);

    // R4: restart
    c = n_to;
    strobe(0); repeat (200) @(negedge clk); strobe(0);
    repeat (295) @(negedge clk);
    chk("R4 no pulse from first", n_to, c);
    @(negedge clk);
    chk("R4 restarted pulse", int'(resp_timeout), 1);

    // R7: gap reload
    gap_len = 16'd5;
    c = n_gd;
    strobe(2); repeat (40) @(negedge clk); strobe(2);
    repeat (79) @(negedge clk);
    chk("R7 no pulse from first", n_gd, c);
    @(negedge clk);
    chk("R7 reloaded pulse", int'(gap_done), 1);

    // R9: tx_end stops watchdog
    c = n_wt;
    strobe(3); repeat (5000) @(negedge clk); strobe(4);
    repeat (11000) @(negedge clk);
    chk("R9 no trip after end", n_wt, c);
    chk("R9 flag clear", int'(wdog_flag), 0);
    // R9: restart
    strobe(3); repeat (3000) @(negedge clk); strobe(3);
    repeat (10687) @(negedge clk);
    chk("R9 no trip from first", n_wt, c);
    @(negedge clk);
    chk("R9 restarted trip", int'(wdog_trip), 1);
    chk("R10 flag set on trip", int'(wdog_flag), 1);
    strobe(5);
    chk("R10 clear", int'(wdog_flag), 0);

    // R10: clear on the trip edge
    strobe(3); repeat (10687) @(negedge clk); strobe(5);
    chk("R10 trip on clear edge", int'(wdog_trip), 1);
    chk("R10 trip beats clear", int'(wdog_flag), 1);
    strobe(5);
    chk("R10 later clear", int'(wdog_flag), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule